// File: doc/BRIEF.md
# External Memory Instruction Fetch Packer

This block supplies instruction words when the processor starts running straight out of a parallel EPROM or flash after reset. In this mode there is no boot loader and no boot-stream format. On each fetch request it runs a series of external reads. Each read holds the read strobe low for a fixed number of system cycles, and the block then packs the returned bytes or halfwords into one 24-bit word.

Three mode strap pins are captured while reset is held. Two strap codes allow direct external execution. The lowest strap bit selects an 8-bit or 16-bit external bus. The first read always goes to a fixed start address, and the address then advances by one on every read. The read length is the bus-clock divider multiplied by (wait states + 1). After reset the defaults are a divider of 128 and 7 wait states.

Top module: `xmem_fetch_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, ext_addr equals START_ADDR (default 0x010000), ext_rd_n is 1 and word_vld is 0.
- R2: Fetches run only when the captured straps are 3'b000 or 3'b001. With any other code, fetch_req is ignored, ext_rd_n stays 1 and ext_addr does not move.
- R3: If captured strap bit 0 is 0 (8-bit bus), one word takes three reads. Only ext_rdata[7:0] is used, and the first byte lands in word_out[23:16], the second in [15:8] and the third in [7:0].
- R4: If captured strap bit 0 is 1 (16-bit bus), one word takes two reads. The first read's full 16 bits fill word_out[23:8]. The second read supplies only ext_rdata[7:0] to word_out[7:0], and its upper 8 bits are ignored.
- R5: ext_addr advances by exactly one at the end of each read and is otherwise stable, so consecutive words use consecutive addresses.
- R6: Each read keeps ext_rd_n low for CLK_DIV*(WAIT_STATES+1) cycles, which is 1024 cycles with the defaults (128, 7). Reads within one word follow each other with no gap, and the data is sampled in the last cycle of each read.
- R7: The straps are captured on every clock edge while rst_n is low. Changes to boot_mode after reset has been released have no effect.
- R8: word_vld is high for exactly one cycle, in the cycle after the last read of a word completes. word_out changes only in that cycle and holds its value until the next word.
- R9: A fetch_req sampled while a fetch is in progress is ignored. A request is accepted only when no fetch is running, and ext_rd_n goes low in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| boot_mode | input | 3 | Mode strap pins |
| fetch_req | input | 1 | Request for one 24-bit instruction word |
| ext_rdata | input | 16 | External memory read data |
| ext_addr | output | 24 | External memory address |
| ext_rd_n | output | 1 | Active-low external read strobe |
| word_out | output | 24 | Assembled instruction word |
| word_vld | output | 1 | One-cycle pulse marking a new word_out |

## Verification
The bench models the external memory with data that depends on the address. In that data the upper byte differs from the lower one, so a design that used the wrong byte on the second 16-bit read, or that assembled least significant part first, would return a wrong word. The bench samples word_vld exactly one cycle before, at, and one cycle after the computed completion edge, and it checks the address after every word. These checks expose an off-by-one in the read counter and an address that skips or repeats. A separate instance with the default parameters checks the 1024-cycle read length. The bench also issues requests while a fetch is running, changes the straps after reset, and uses every non-executing strap code, to catch a design that starts extra reads or still follows the strap pins.

// File: rtl/xmem_fetch_packer.sv
module xmem_fetch_packer #(
  parameter int          CLK_DIV     = 128,
  parameter int          WAIT_STATES = 7,
  parameter logic [23:0] START_ADDR  = 24'h010000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  boot_mode,
  input  logic        fetch_req,
  input  logic [15:0] ext_rdata,
  output logic [23:0] ext_addr,
  output logic        ext_rd_n,
  output logic [23:0] word_out,
  output logic        word_vld
);
  localparam int RD_CYC = CLK_DIV * (WAIT_STATES + 1);
  localparam int CW     = $clog2(RD_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RD_CYC - 1);

  logic [2:0]    mode_q;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [1:0]    part;
  logic [23:0]   acc;
  logic [23:0]   nxt_acc;

  wire wide      = mode_q[0];
  wire run_ok    = (mode_q[2:1] == 2'b00);
  wire last_part = wide ? (part == 2'd1) : (part == 2'd2);
  wire read_done = busy && (cnt == '0);

  always_comb begin
    if (!wide)
      nxt_acc = {acc[15:0], ext_rdata[7:0]};
    else if (part == 2'd0)
      nxt_acc = {ext_rdata, 8'h00};
    else
      nxt_acc = {acc[23:8], ext_rdata[7:0]};
  end

  assign ext_rd_n = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= boot_mode;
      busy     <= 1'b0;
      cnt      <= '0;
      part     <= 2'd0;
      acc      <= '0;
      ext_addr <= START_ADDR;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!busy) begin
        if (fetch_req && run_ok) begin
          busy <= 1'b1;
          cnt  <= CNT_LOAD;
          part <= 2'd0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        acc      <= nxt_acc;
        ext_addr <= ext_addr + 24'd1;
        if (last_part) begin
          busy     <= 1'b0;
          word_out <= nxt_acc;
          word_vld <= 1'b1;
        end else begin
          part <= part + 2'd1;
          cnt  <= CNT_LOAD;
        end
      end
    end
  end
endmodule

// File: rtl/xmem_fetch_packer_chk.sv
module xmem_fetch_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode_q,
  input logic        read_done,
  input logic [23:0] ext_addr,
  input logic        ext_rd_n,
  input logic [23:0] word_out,
  input logic        word_vld
);
  a_r8_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (word_out != $past(word_out)) |-> word_vld);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |=> (ext_addr == $past(ext_addr) + 24'd1));

  a_r5_addr_still: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd_n |=> $stable(ext_addr));

  a_r2_no_read_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:1] != 2'b00) |-> ext_rd_n);

  a_r7_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  a_r9_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ext_rd_n);
endmodule

bind xmem_fetch_packer xmem_fetch_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .read_done(read_done),
  .ext_addr(ext_addr), .ext_rd_n(ext_rd_n), .word_out(word_out),
  .word_vld(word_vld)
);

// File: tb/xmem_fetch_packer_tb.sv
module xmem_fetch_packer_tb;
  localparam int DIV = 2, WS = 1, L = DIV * (WS + 1);
  localparam logic [23:0] BASE = 24'h010000;

  logic clk = 0, rst_n = 0, req = 0, dreq = 0;
  logic [2:0] boot_mode = 3'b000;
  logic [15:0] rdata, drdata;
  logic [23:0] addr, daddr, word, dword;
  logic rd_n, vld, drd_n, dvld;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] dat(input logic [23:0] a);
    logic [7:0] lo;
    lo = a[7:0] * 8'd3 + 8'h11;
    return {a[7:0] ^ 8'hA5, lo};
  endfunction

  assign rdata  = dat(addr);
  assign drdata = dat(daddr);

  xmem_fetch_packer #(.CLK_DIV(DIV), .WAIT_STATES(WS)) u_dut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .fetch_req(req),
    .ext_rdata(rdata), .ext_addr(addr), .ext_rd_n(rd_n),
    .word_out(word), .word_vld(vld));

  xmem_fetch_packer u_def (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .fetch_req(dreq),
    .ext_rdata(drdata), .ext_addr(daddr), .ext_rd_n(drd_n),
    .word_out(dword), .word_vld(dvld));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk); rst_n = 0; boot_mode = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [23:0] exp_word(input bit wide, input logic [23:0] b);
    if (wide) return {dat(b), dat(b + 24'd1)[7:0]};
    return {dat(b)[7:0], dat(b + 24'd1)[7:0], dat(b + 24'd2)[7:0]};
  endfunction

  task automatic fetch(input bit wide, input logic [23:0] b, input bit extra_req);
    int p, bad;
    p = wide ? 2 : 3;
    bad = 0;
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    chk("R9 strobe low after accept", rd_n, 0);
    chk("R5 first address", addr, b);
    for (int i = 0; i < p * L - 1; i++) begin
      if (extra_req && i == 2) req = 1;
      if (extra_req && i == 3) req = 0;
      if (rd_n !== 1'b0 || vld !== 1'b0) bad++;
      @(negedge clk);
    end
    req = 0;
    chk("R6 strobe held for whole reads", bad, 0);
    chk("R8 no early valid", vld, 0);
    @(negedge clk);
    chk("R8 valid at completion", vld, 1);
    chk(wide ? "R4 16-bit packing" : "R3 8-bit packing", word, exp_word(wide, b));
    chk("R5 address advanced per read", addr, b + 24'(p));
    chk("R6 strobe released", rd_n, 1);
    @(negedge clk);
    chk("R8 valid single cycle", vld, 0);
    chk("R8 word held", word, exp_word(wide, b));
  endtask

  task automatic idle_watch(input string r, input int n, input logic [23:0] a);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rd_n !== 1'b1 || vld !== 1'b0 || addr !== a) bad++;
    end
    chk(r, bad, 0);
  endtask

  initial begin
    logic [23:0] b;
    int cyc;
    do_reset(3'b000);
    chk("R1 reset address", addr, BASE);
    chk("R1 reset strobe", rd_n, 1);
    chk("R1 reset valid", vld, 0);
    @(negedge clk);
    chk("R1 first cycle address", addr, BASE);

    for (int w = 0; w < 2; w++) begin
      do_reset(3'(w));
      b = BASE;
      for (int k = 0; k < 6; k++) begin
        fetch(w[0], b, 0);
        b = b + (w[0] ? 24'd2 : 24'd3);
      end
      fetch(w[0], b, 1);
      b = b + (w[0] ? 24'd2 : 24'd3);
      idle_watch("R9 request during fetch ignored", 8, b);
    end

    for (int s = 2; s < 8; s++) begin
      do_reset(3'(s));
      @(negedge clk); req = 1;
      idle_watch("R2 non-executing strap ignores requests", 12, BASE);
      req = 0;
    end

    do_reset(3'b001);
    @(negedge clk); boot_mode = 3'b000;
    fetch(1'b1, BASE, 0);
    boot_mode = 3'b110;
    fetch(1'b1, BASE + 24'd2, 0);
    chk("R7 strap change after reset ignored", addr, BASE + 24'd4);

    do_reset(3'b000);
    @(negedge clk); dreq = 1;
    @(negedge clk); dreq = 0;
    chk("R5 default start address", daddr, 24'h010000);
    cyc = 0;
    while (dvld !== 1'b1 && cyc < 5000) begin
      @(negedge clk); cyc++;
    end
    chk("R6 default 3 reads of 1024 cycles", cyc, 3 * 1024);
    chk("R3 default instance word", dword, exp_word(1'b0, 24'h010000));

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule